// File: doc/BRIEF.md
# Accelerator Control Register Interface

This block is the bus-facing register file of a CPU accelerator card. It decodes an eight-location I/O window at offsets 0 to 7. At several offsets a read and a write mean different things, and some accesses have side effects. Software must first open the file with a key sequence of four matching writes at offset 2. Until then every read returns the open-bus value and only offset 2 accepts writes. Once the file is open, software can set the accelerated speed, the delay options and the per-slot slow-down enables. It can also switch the card off or back on, ask for a cold reload on the next reset, and inspect the card status and the last cache tag.

The outputs drive the card's speed and delay logic. They give the speed code, the option bits, the slot enables, the card enable, an annunciator enable that is high while the file is locked, and a one-cycle pulse that restarts any delay in progress whenever the window is written. Read data is registered and appears on the cycle after the read strobe.

Top module: `accel_ctrl`

## Requirements
- R1: The file unlocks after four writes to offset 2 whose data bits 7:4 equal 4'h5, with bits 3:0 ignored. While locked, any other write (another value at offset 2, or any write at another offset) restarts the count at zero.
- R2: While locked, every read returns OPEN_BUS (8'hFF) and has no side effect. Writes to offsets other than 2 change no register.
- R3: While unlocked, a write to offset 2 with bits 7:4 equal to 4'hA locks the file. ann_en_o is 1 exactly while the file is locked.
- R4: While unlocked, a write to offset 2 whose bits 7:4 are neither 4'h5 nor 4'hA clears card_en_o. A write of any value to offset 3 sets it again. A 4'h5 write while unlocked has no effect.
- R5: A write to offset 5 loads speed_o from data bits 7:4. A read of offset 2 returns {speed, 4'hF}.
- R6: Offset 1 is read/write, and bits 7:3 drive opt_o[4:0]. On a read, bit 2 is the last-reset-warm flag, bit 1 is dma_i and bit 0 is the MODEL_GS parameter (default 1).
- R7: Offset 4 is an 8-bit read/write register that drives slot_en_o, where bits 7:1 are slots 7..1 and bit 0 is the speaker.
- R8: A read of offset 3 returns {ms_clk_i, tag-updated flag, opt_o[4], !card_en_o, delay_i, rombank_i, CACHE_SZ[1:0]}, with CACHE_SZ defaulting to 2'b11.
- R9: tag_we_i stores tag_d_i and sets the tag-updated flag. A read of offset 7 returns the stored tag and clears the flag. A read of offset 6 returns the stored tag and makes the next tag write store TRASH_TAG (8'h00).
- R10: A write to offset 0 marks the next reset as cold. On pwr_rst, or on rst after that mark, speed loads sw_speed_i, opt loads DEF_OPT (0) and slots load DEF_SLOT (0), and the warm flag becomes 0. On rst without the mark the settings are kept and the warm flag becomes 1.
- R11: Every reset locks the file, clears the key count and sets card_en_o. A read of offset 5 returns bank_i, and a read of offset 0 returns OPEN_BUS.
- R12: Every write to the window, locked or not, makes delay_rst_o high for exactly the following cycle.
- R13: rdata changes only on the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (warm unless marked cold) |
| pwr_rst | input | 1 | Synchronous active-high power-on reset (always cold) |
| bus_addr | input | 3 | Window offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sw_speed_i | input | 4 | Switch speed loaded on cold reset |
| dma_i | input | 1 | DMA flag for offset 1 reads |
| ms_clk_i | input | 1 | 1 ms square wave for status |
| delay_i | input | 1 | Delay in effect, for status |
| rombank_i | input | 1 | ROM bank, for status |
| bank_i | input | 8 | Current CPU bank, read at offset 5 |
| tag_we_i | input | 1 | Tag write from cache side |
| tag_d_i | input | 8 | Tag value |
| speed_o | output | 4 | Speed code |
| opt_o | output | 5 | Option bits (cache disable, paddle, external, counter, follow) |
| slot_en_o | output | 8 | Slot and speaker slow-down enables |
| card_en_o | output | 1 | Card enabled |
| ann_en_o | output | 1 | Annunciators enabled (file locked) |
| delay_rst_o | output | 1 | Delay restart pulse |

## Verification
The bench sweeps all 256 values written to offset 2 while the file is open. A design that decodes the nibbles wrongly would lock on a disable code, switch the card off on a key write, or ignore the enable at offset 3. It breaks the key sequence both with a wrong value and with a write to another offset, so a counter that only resets on bad key values would open the file early. It checks that a tag read while locked neither returns data nor clears the flag, and that the read at offset 6 turns only the next tag write into the trash value. Warm and cold resets are compared, so a design that always reloads or never reloads would report the wrong speed and the wrong warm bit.

// File: rtl/accel_pkg.sv
package accel_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int SPW = DW / 2;

  localparam logic [AW-1:0] OFS_COLD = 3'd0;
  localparam logic [AW-1:0] OFS_OPT  = 3'd1;
  localparam logic [AW-1:0] OFS_KEY  = 3'd2;
  localparam logic [AW-1:0] OFS_STAT = 3'd3;
  localparam logic [AW-1:0] OFS_SLOT = 3'd4;
  localparam logic [AW-1:0] OFS_SPD  = 3'd5;
  localparam logic [AW-1:0] OFS_TAGX = 3'd6;
  localparam logic [AW-1:0] OFS_TAGR = 3'd7;

  localparam logic [3:0] KEY_OPEN = 4'h5;
  localparam logic [3:0] KEY_SHUT = 4'hA;
endpackage

// File: rtl/accel_lock.sv
module accel_lock
  import accel_pkg::*;
#(
  parameter int KEY_WRITES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    key_i,
  output logic          locked_o,
  output logic          kill_o
);
  localparam int CW = $clog2(KEY_WRITES);
  localparam logic [CW-1:0] LAST = CW'(KEY_WRITES - 1);

  logic [CW-1:0] cnt_q;
  logic          locked_q;
  logic          key_hit;
  logic          open_hit;
  logic          shut_hit;

  assign key_hit  = wr_i && (addr_i == OFS_KEY);
  assign open_hit = key_hit && (key_i == KEY_OPEN);
  assign shut_hit = key_hit && (key_i == KEY_SHUT);
  assign kill_o   = key_hit && !locked_q && !open_hit && !shut_hit;
  assign locked_o = locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      cnt_q    <= '0;
    end else if (wr_i) begin
      if (locked_q) begin
        if (open_hit) begin
          if (cnt_q == LAST) begin
            locked_q <= 1'b0;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end else if (shut_hit) begin
        locked_q <= 1'b1;
        cnt_q    <= '0;
      end
    end
  end

  // R1: last matching write opens the file
  a_r1_unlock: assert property (@(posedge clk) disable iff (rst)
    (locked_q && open_hit && cnt_q == LAST) |=> !locked_q);
  // R1: a non-matching write while locked restarts the count
  a_r1_break: assert property (@(posedge clk) disable iff (rst)
    (wr_i && locked_q && !open_hit) |=> (cnt_q == '0 && locked_q));
  // R3: shut key locks
  a_r3_relock: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && shut_hit) |=> locked_q);
  // R11: reset leaves the file locked with a clear count
  a_r11_rst: assert property (@(posedge clk)
    rst |=> (locked_q && cnt_q == '0));
endmodule

// File: rtl/accel_tag.sv
module accel_tag
  import accel_pkg::*;
#(
  parameter logic [DW-1:0] TRASH_TAG = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tag_we_i,
  input  logic [DW-1:0] tag_d_i,
  input  logic          rd_clr_i,
  input  logic          rd_trash_i,
  output logic [DW-1:0] tag_o,
  output logic          upd_o
);
  logic [DW-1:0] tag_q;
  logic          upd_q;
  logic          trash_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q   <= '0;
      upd_q   <= 1'b0;
      trash_q <= 1'b0;
    end else begin
      if (tag_we_i) begin
        tag_q   <= trash_q ? TRASH_TAG : tag_d_i;
        upd_q   <= 1'b1;
        trash_q <= 1'b0;
      end else if (rd_clr_i) begin
        upd_q <= 1'b0;
      end
      if (rd_trash_i) trash_q <= 1'b1;
    end
  end

  assign tag_o = tag_q;
  assign upd_o = upd_q;

  // R9: a tag write raises the flag
  a_r9_set: assert property (@(posedge clk) disable iff (rst)
    tag_we_i |=> upd_q);
  // R9: reading offset 7 clears the flag
  a_r9_clr: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && !tag_we_i) |=> !upd_q);
  // R9: an armed tag write stores the trash value
  a_r9_trash: assert property (@(posedge clk) disable iff (rst)
    (tag_we_i && trash_q) |=> (tag_q == TRASH_TAG));
endmodule

// File: rtl/accel_cfg.sv
module accel_cfg
  import accel_pkg::*;
#(
  parameter logic [4:0]    DEF_OPT  = 5'b00000,
  parameter logic [DW-1:0] DEF_SLOT = 8'h00
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_rst,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           kill_i,
  input  logic [SPW-1:0] sw_speed_i,
  output logic [4:0]     opt_o,
  output logic [DW-1:0]  slot_o,
  output logic [SPW-1:0] speed_o,
  output logic           card_en_o,
  output logic           warm_o
);
  logic [4:0]     opt_q;
  logic [DW-1:0]  slot_q;
  logic [SPW-1:0] speed_q;
  logic           card_q;
  logic           cold_q;
  logic           warm_q;

  always_ff @(posedge clk) begin
    if (pwr_rst || (rst && cold_q)) begin
      opt_q   <= DEF_OPT;
      slot_q  <= DEF_SLOT;
      speed_q <= sw_speed_i;
      warm_q  <= 1'b0;
      cold_q  <= 1'b0;
      card_q  <= 1'b1;
    end else if (rst) begin
      warm_q <= 1'b1;
      card_q <= 1'b1;
    end else begin
      if (kill_i) card_q <= 1'b0;
      if (wr_en_i) begin
        case (addr_i)
          OFS_COLD: cold_q  <= 1'b1;
          OFS_OPT:  opt_q   <= wdata_i[DW-1:DW-5];
          OFS_STAT: card_q  <= 1'b1;
          OFS_SLOT: slot_q  <= wdata_i;
          OFS_SPD:  speed_q <= wdata_i[DW-1:DW-SPW];
          default:  ;
        endcase
      end
    end
  end

  assign opt_o     = opt_q;
  assign slot_o    = slot_q;
  assign speed_o   = speed_q;
  assign card_en_o = card_q;
  assign warm_o    = warm_q;

  // R5: speed write loads the upper nibble
  a_r5_speed: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    (wr_en_i && addr_i == OFS_SPD) |=> (speed_q == $past(wdata_i[DW-1:DW-SPW])));
  // R4: disable code turns the card off
  a_r4_kill: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    kill_i |=> !card_q);
  // R10: warm reset keeps the settings
  a_r10_warm: assert property (@(posedge clk)
    (rst && !pwr_rst && !cold_q) |=> (warm_q && $stable(speed_q) && $stable(slot_q)));
  // R10: cold reset reloads defaults
  a_r10_cold: assert property (@(posedge clk)
    pwr_rst |=> (!warm_q && slot_q == DEF_SLOT && opt_q == DEF_OPT));
endmodule

// File: rtl/accel_ctrl.sv
module accel_ctrl
  import accel_pkg::*;
#(
  parameter int            KEY_WRITES = 4,
  parameter logic [DW-1:0] OPEN_BUS   = 8'hFF,
  parameter logic [DW-1:0] TRASH_TAG  = 8'h00,
  parameter logic [1:0]    CACHE_SZ   = 2'b11,
  parameter logic          MODEL_GS   = 1'b1,
  parameter logic [4:0]    DEF_OPT    = 5'b00000,
  parameter logic [DW-1:0] DEF_SLOT   = 8'h00
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  rdata,
  input  logic [SPW-1:0] sw_speed_i,
  input  logic           dma_i,
  input  logic           ms_clk_i,
  input  logic           delay_i,
  input  logic           rombank_i,
  input  logic [DW-1:0]  bank_i,
  input  logic           tag_we_i,
  input  logic [DW-1:0]  tag_d_i,
  output logic [SPW-1:0] speed_o,
  output logic [4:0]     opt_o,
  output logic [DW-1:0]  slot_en_o,
  output logic           card_en_o,
  output logic           ann_en_o,
  output logic           delay_rst_o
);
  logic          any_rst;
  logic          locked;
  logic          kill;
  logic          warm;
  logic          tag_upd;
  logic [DW-1:0] tag_val;
  logic          rd_open;
  logic          rd_q;

  assign any_rst = rst || pwr_rst;
  assign rd_open = bus_rd && !locked;

  accel_lock #(.KEY_WRITES(KEY_WRITES)) u_lock (
    .clk(clk), .rst(any_rst), .wr_i(bus_wr), .addr_i(bus_addr),
    .key_i(bus_wdata[DW-1:DW-4]), .locked_o(locked), .kill_o(kill)
  );

  accel_cfg #(.DEF_OPT(DEF_OPT), .DEF_SLOT(DEF_SLOT)) u_cfg (
    .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .wr_en_i(bus_wr && !locked),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .kill_i(kill),
    .sw_speed_i(sw_speed_i), .opt_o(opt_o), .slot_o(slot_en_o),
    .speed_o(speed_o), .card_en_o(card_en_o), .warm_o(warm)
  );

  accel_tag #(.TRASH_TAG(TRASH_TAG)) u_tag (
    .clk(clk), .rst(any_rst), .tag_we_i(tag_we_i), .tag_d_i(tag_d_i),
    .rd_clr_i(rd_open && bus_addr == OFS_TAGR),
    .rd_trash_i(rd_open && bus_addr == OFS_TAGX),
    .tag_o(tag_val), .upd_o(tag_upd)
  );

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rdata       <= OPEN_BUS;
      delay_rst_o <= 1'b0;
      rd_q        <= 1'b0;
    end else begin
      delay_rst_o <= bus_wr;
      rd_q        <= bus_rd;
      if (bus_rd) begin
        if (locked) begin
          rdata <= OPEN_BUS;
        end else begin
          case (bus_addr)
            OFS_OPT:  rdata <= {opt_o, warm, dma_i, MODEL_GS};
            OFS_KEY:  rdata <= {speed_o, {(DW-SPW){1'b1}}};
            OFS_STAT: rdata <= {ms_clk_i, tag_upd, opt_o[4], !card_en_o,
                                delay_i, rombank_i, CACHE_SZ};
            OFS_SLOT: rdata <= slot_en_o;
            OFS_SPD:  rdata <= bank_i;
            OFS_TAGX: rdata <= tag_val;
            OFS_TAGR: rdata <= tag_val;
            default:  rdata <= OPEN_BUS;
          endcase
        end
      end
    end
  end

  assign ann_en_o = locked;

  // R2: locked reads float
  a_r2_open: assert property (@(posedge clk) disable iff (any_rst)
    (bus_rd && locked) |=> (rdata == OPEN_BUS));
  // R2: locked writes off the key offset leave settings alone
  a_r2_ignore: assert property (@(posedge clk) disable iff (any_rst)
    (bus_wr && locked && bus_addr != OFS_KEY) |=>
      ($stable(speed_o) && $stable(slot_en_o) && $stable(opt_o)));
  // R12: each write pulses the delay restart
  a_r12_pulse: assert property (@(posedge clk) disable iff (any_rst)
    bus_wr |=> delay_rst_o);
  // R13: read data holds without a strobe
  a_r13_hold: assert property (@(posedge clk) disable iff (any_rst)
    (!bus_rd && !rd_q) |=> $stable(rdata));
endmodule

// File: tb/sim_accel_ctrl.sv
module sim_accel_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, pwr_rst;
  logic [2:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, rdata;
  logic [3:0] sw_speed_i;
  logic       dma_i, ms_clk_i, delay_i, rombank_i;
  logic [7:0] bank_i;
  logic       tag_we_i;
  logic [7:0] tag_d_i;
  logic [3:0] speed_o;
  logic [4:0] opt_o;
  logic [7:0] slot_en_o;
  logic       card_en_o, ann_en_o, delay_rst_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_ctrl u0 (
    .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rdata(rdata),
    .sw_speed_i(sw_speed_i), .dma_i(dma_i), .ms_clk_i(ms_clk_i),
    .delay_i(delay_i), .rombank_i(rombank_i), .bank_i(bank_i),
    .tag_we_i(tag_we_i), .tag_d_i(tag_d_i), .speed_o(speed_o),
    .opt_o(opt_o), .slot_en_o(slot_en_o), .card_en_o(card_en_o),
    .ann_en_o(ann_en_o), .delay_rst_o(delay_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] q);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    q = rdata;
  endtask

  task automatic tagw(input logic [7:0] d);
    tag_d_i = d; tag_we_i = 1'b1;
    @(negedge clk);
    tag_we_i = 1'b0;
  endtask

  task automatic pulse_rst(input bit por);
    if (por) pwr_rst = 1'b1; else rst = 1'b1;
    @(negedge clk);
    pwr_rst = 1'b0; rst = 1'b0;
  endtask

  task automatic unlock();
    for (int i = 0; i < 4; i++) wr(3'd2, {4'h5, 4'(i * 5)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    rst = 0; pwr_rst = 0; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    sw_speed_i = 4'h3; dma_i = 1; ms_clk_i = 0; delay_i = 0; rombank_i = 0;
    bank_i = 8'h2C; tag_we_i = 0; tag_d_i = 0;
    @(negedge clk);
    pulse_rst(1'b1);

    // reset state
    check("R11 locked after reset", ann_en_o, 1);
    check("R11 card on after reset", card_en_o, 1);
    check("R10 speed from switches", speed_o, 4'h3);
    check("R10 slots default", slot_en_o, 8'h00);
    check("R10 opts default", opt_o, 5'h00);

    // locked access
    wr(3'd4, 8'h55);
    check("R2 locked write ignored", slot_en_o, 8'h00);
    check("R12 pulse after write", delay_rst_o, 1);
    @(negedge clk);
    check("R12 pulse one cycle", delay_rst_o, 0);
    rd(3'd4, q);
    check("R2 locked read open bus", q, 8'hFF);

    // broken sequences
    wr(3'd2, 8'h51); wr(3'd2, 8'h52); wr(3'd2, 8'h53);
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h54); wr(3'd2, 8'h55); wr(3'd2, 8'h56);
    check("R1 break by other offset", ann_en_o, 1);
    wr(3'd2, 8'h60);
    wr(3'd2, 8'h57);
    check("R1 break by bad key", ann_en_o, 1);
    wr(3'd2, 8'h58); wr(3'd2, 8'h59);
    check("R1 three after break", ann_en_o, 1);
    wr(3'd2, 8'h5F);
    check("R1 fourth opens", ann_en_o, 0);

    // speed sweep
    for (int s = 0; s < 16; s++) begin
      wr(3'd5, {4'(s), 4'(15 - s)});
      check("R5 speed out", speed_o, s);
      rd(3'd2, q);
      check("R5 speed readback", q, {4'(s), 4'hF});
    end

    // slot sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd4, 8'(v));
      check("R7 slot out", slot_en_o, v);
      rd(3'd4, q);
      check("R7 slot readback", q, v);
    end

    // option sweep
    for (int v = 0; v < 32; v++) begin
      dma_i = v[0];
      wr(3'd1, {5'(v), 3'(v * 3)});
      check("R6 opt out", opt_o, v);
      rd(3'd1, q);
      check("R6 opt readback", q, {5'(v), 1'b0, v[0], 1'b1});
    end
    wr(3'd1, 8'h00);

    // status sweep
    for (int v = 0; v < 8; v++) begin
      ms_clk_i = v[2]; delay_i = v[1]; rombank_i = v[0];
      rd(3'd3, q);
      check("R8 status", q, {v[2], 1'b0, 1'b0, 1'b0, v[1], v[0], 2'b11});
    end
    ms_clk_i = 0; delay_i = 0; rombank_i = 0;
    wr(3'd1, 8'h80);
    rd(3'd3, q);
    check("R8 status cache bit", q, 8'h23);
    wr(3'd1, 8'h00);

    // tags
    tagw(8'h3C);
    rd(3'd3, q);
    check("R9 flag set", q[6], 1);
    rd(3'd7, q);
    check("R9 read tag", q, 8'h3C);
    rd(3'd3, q);
    check("R9 flag cleared", q[6], 0);
    rd(3'd6, q);
    check("R9 read tag via 6", q, 8'h3C);
    tagw(8'h77);
    rd(3'd7, q);
    check("R9 trash stored", q, 8'h00);
    tagw(8'h12);
    rd(3'd7, q);
    check("R9 normal after trash", q, 8'h12);

    // misc reads
    rd(3'd5, q);
    check("R11 bank read", q, 8'h2C);
    rd(3'd0, q);
    check("R11 offset 0 read", q, 8'hFF);
    @(negedge clk); @(negedge clk);
    check("R13 rdata holds", rdata, 8'hFF);

    // key sweep while open
    for (int v = 0; v < 256; v++) begin
      logic [3:0] hi;
      hi = 4'(v >> 4);
      wr(3'd2, 8'(v));
      if (hi == 4'h5) begin
        check("R4 open key no effect lock", ann_en_o, 0);
        check("R4 open key no effect card", card_en_o, 1);
      end else if (hi == 4'hA) begin
        check("R3 shut key locks", ann_en_o, 1);
        check("R3 card untouched", card_en_o, 1);
        unlock();
      end else begin
        check("R4 disable code", card_en_o, 0);
        check("R4 still open", ann_en_o, 0);
        if (v == 0) begin
          rd(3'd3, q);
          check("R8 board disabled bit", q[4], 1);
        end
        wr(3'd3, 8'(v));
        check("R4 enable write", card_en_o, 1);
      end
    end

    // locked tag read has no side effect
    tagw(8'h44);
    wr(3'd2, 8'hA0);
    rd(3'd7, q);
    check("R2 locked tag read", q, 8'hFF);
    unlock();
    rd(3'd3, q);
    check("R2 locked read kept flag", q[6], 1);

    // warm reset
    wr(3'd5, 8'h90);
    wr(3'd4, 8'hA5);
    pulse_rst(1'b0);
    check("R11 warm reset locks", ann_en_o, 1);
    check("R10 warm keeps speed", speed_o, 4'h9);
    check("R10 warm keeps slots", slot_en_o, 8'hA5);
    unlock();
    rd(3'd1, q);
    check("R10 warm flag set", q[2], 1);

    // cold reset via offset 0
    wr(3'd2, 8'h00);
    check("R4 card off before reset", card_en_o, 0);
    wr(3'd0, 8'h11);
    pulse_rst(1'b0);
    check("R10 cold reload speed", speed_o, 4'h3);
    check("R10 cold reload slots", slot_en_o, 8'h00);
    check("R11 card on after reset", card_en_o, 1);
    unlock();
    rd(3'd1, q);
    check("R10 warm flag cleared", q[2], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule